// File: doc/BRIEF.md
# PWM Event Trigger with Per-Output Prescaler

This block sits beside a PWM time-base counter and turns chosen counter events into three request pulses: one interrupt request and two ADC start-of-conversion strobes (SOC-A and SOC-B). On each clock where the time base signals a tick, the block compares the counter with zero, with the period and with the two compare values, and it takes the count direction into account. Each output selects one of eight sources with a 3-bit code and has its own enable bit.

Each output has a 4-bit prescaler. The prescaler counts qualified events and fires a one-clock pulse on every Nth one, where N is 1 to 15. A period of 0 keeps that output silent. Firing sets a per-output pending flag. Software can clear a flag or force an event through a small register port. While the interrupt flag is pending, the interrupt channel stops counting and stops pulsing. The SOC channels keep running whatever the state of their flags.

Top module: `pwm_evt_trigger`

## Requirements
- R1: After reset, every register reads 0, every prescale counter and flag is 0, and all three pulse outputs are low.
- R2: The register offsets are 0 = selection, 1 = prescale, 2 = flags (read only), 3 = clear (write only), and 4 = force (write only). In the selection register, bit 3 is the interrupt enable and bits 2:0 its source. Bit 11 is the SOC-A enable and bits 10:8 its source. Bit 15 is the SOC-B enable and bits 14:12 its source. Bits 7:4 are reserved: they always read 0 and writes to them are dropped. In the prescale register, bits 3:0 hold the interrupt period, bits 7:4 the SOC-A period and bits 11:8 the SOC-B period. Bits 15:12 are reserved and read 0. The flags, clear and force registers all use bit 0 = interrupt, bit 1 = SOC-A and bit 2 = SOC-B.
- R3: Source code 001 qualifies on counter == 0, code 010 on counter == period, and code 011 on either. A cycle in which the counter equals zero and period together counts as one event.
- R4: Codes 100 and 101 qualify on counter == compare A while counting up (direction 1) or down (direction 0) respectively. Codes 110 and 111 do the same for compare B. A match in the other direction is not an event.
- R5: Code 000 selects the external digital-compare input for SOC-A (input A) and SOC-B (input B). For the interrupt, code 000 never produces an event.
- R6: A selection enable bit of 0 stops the source events of that output. A value of 1 passes them.
- R7: Source events are counted only on tick cycles. The Nth counted event resets the counter and sets the flag, and the output pulses high for exactly one clock. The pulse appears on the clock after the tick or force cycle that fired it.
- R8: A prescale period of 0 means no pulse and no flag for that output.
- R9: While the interrupt flag is set, interrupt events are neither counted nor pulsed.
- R10: SOC pulses keep firing while their own flags are set.
- R11: Writing 1 to a clear bit resets that flag. Writing 0 has no effect.
- R12: Writing 1 to a force bit feeds one qualified event into that prescaler, regardless of the enable bit and the source code. It is still subject to the period and to R9.
- R13: A clear and a flag-setting fire in the same cycle leave the flag set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tb_tick | input | 1 | Time-base tick; events are sampled only when high |
| tb_count | input | 16 | Time-base counter value |
| tb_dir_up | input | 1 | Count direction, 1 = up, 0 = down |
| tb_period | input | 16 | Time-base period value |
| cmp_a | input | 16 | Compare value A |
| cmp_b | input | 16 | Compare value B |
| dc_evt_a | input | 1 | External digital-compare event for SOC-A |
| dc_evt_b | input | 1 | External digital-compare event for SOC-B |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register offset |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data (combinational on reg_addr) |
| irq_pulse | output | 1 | Interrupt request pulse |
| soca_pulse | output | 1 | SOC-A pulse |
| socb_pulse | output | 1 | SOC-B pulse |

## Verification
The hardest situation to reach from the ports is a clear write that lands in the same clock as a tick that completes a prescale count (R13). A plain write task would separate the two by a cycle. The bench therefore raises the tick and the clear strobe together at one falling edge and then reads the flag back. The single-event case for code 011 is also hard to reach. The bench covers it by setting the period to zero, holding the counter at zero with a prescale of 2, and showing that the first tick does not fire and the second one does.

// File: rtl/pwm_et_pkg.sv
package pwm_et_pkg;
  localparam int NCH     = 3;
  localparam int CH_IRQ  = 0;
  localparam int CH_SOCA = 1;
  localparam int CH_SOCB = 2;

  typedef enum logic [2:0] {
    SRC_DC  = 3'd0,
    SRC_ZRO = 3'd1,
    SRC_PRD = 3'd2,
    SRC_ZP  = 3'd3,
    SRC_AUP = 3'd4,
    SRC_ADN = 3'd5,
    SRC_BUP = 3'd6,
    SRC_BDN = 3'd7
  } src_sel_e;

  typedef struct packed {
    logic at_zero;
    logic at_prd;
    logic a_up;
    logic a_dn;
    logic b_up;
    logic b_dn;
  } tb_evt_t;

  // One source code against the decoded time-base conditions
  function automatic logic src_hit(input logic [2:0] code, input tb_evt_t e,
                                   input logic dc, input logic dc_ok);
    logic h;
    case (src_sel_e'(code))
      SRC_DC:  h = dc_ok & dc;
      SRC_ZRO: h = e.at_zero;
      SRC_PRD: h = e.at_prd;
      SRC_ZP:  h = e.at_zero | e.at_prd;
      SRC_AUP: h = e.a_up;
      SRC_ADN: h = e.a_dn;
      SRC_BUP: h = e.b_up;
      default: h = e.b_dn;
    endcase
    return h;
  endfunction
endpackage

// File: rtl/et_tb_decode.sv
module et_tb_decode #(
  parameter int CW = 16
) (
  input  logic [CW-1:0]       count,
  input  logic                dir_up,
  input  logic [CW-1:0]       period,
  input  logic [CW-1:0]       cmpa,
  input  logic [CW-1:0]       cmpb,
  output pwm_et_pkg::tb_evt_t ev
);
  logic eq_a, eq_b;
  always_comb begin
    eq_a       = (count == cmpa);
    eq_b       = (count == cmpb);
    ev.at_zero = (count == '0);
    ev.at_prd  = (count == period);
    ev.a_up    = eq_a &  dir_up;
    ev.a_dn    = eq_a & ~dir_up;
    ev.b_up    = eq_b &  dir_up;
    ev.b_dn    = eq_b & ~dir_up;
  end
endmodule

// File: rtl/et_src_mux.sv
module et_src_mux #(
  parameter bit DC_ALLOWED = 1'b1
) (
  input  logic                tick,
  input  logic                en,
  input  logic [2:0]          code,
  input  pwm_et_pkg::tb_evt_t ev,
  input  logic                dc,
  input  logic                force_ev,
  output logic                qual
);
  logic src_ev;
  always_comb begin
    src_ev = tick & en & pwm_et_pkg::src_hit(code, ev, dc, DC_ALLOWED);
    qual   = src_ev | force_ev;
  end
endmodule

// File: rtl/et_prescaler.sv
module et_prescaler #(
  parameter int PSC_W      = 4,
  parameter bit HOLD_ON_FL = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             qual,
  input  logic [PSC_W-1:0] per,
  input  logic             clr,
  output logic             fire,
  output logic             pulse,
  output logic             flag,
  output logic [PSC_W-1:0] cnt
);
  // next count and wrap test kept in functions
  function automatic logic [PSC_W:0] cnt_inc(input logic [PSC_W-1:0] c);
    return {1'b0, c} + {{PSC_W{1'b0}}, 1'b1};
  endfunction
  function automatic logic reaches(input logic [PSC_W-1:0] c, input logic [PSC_W-1:0] p);
    return (p != '0) && (cnt_inc(c) >= {1'b0, p});
  endfunction

  logic             blocked, counting;
  logic [PSC_W:0]   nxt;
  logic [PSC_W-1:0] cnt_d;

  always_comb begin
    blocked  = HOLD_ON_FL & flag;
    counting = qual & ~blocked & (per != '0);
    nxt      = cnt_inc(cnt);
    fire     = counting & reaches(cnt, per);
    if (fire)          cnt_d = '0;
    else if (counting) cnt_d = nxt[PSC_W-1:0];
    else               cnt_d = cnt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= '0;
      pulse <= 1'b0;
      flag  <= 1'b0;
    end else begin
      cnt   <= cnt_d;
      pulse <= fire;
      if (fire)     flag <= 1'b1;
      else if (clr) flag <= 1'b0;
    end
  end
endmodule

// File: rtl/et_regs.sv
module et_regs #(
  parameter int DW    = 16,
  parameter int AW    = 3,
  parameter int NCH   = 3,
  parameter int PSC_W = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr,
  input  logic [AW-1:0]  addr,
  input  logic [DW-1:0]  wdata,
  input  logic [NCH-1:0] flags,
  output logic [DW-1:0]  sel_q,
  output logic [DW-1:0]  psc_q,
  output logic [NCH-1:0] clr_vec,
  output logic [NCH-1:0] frc_vec,
  output logic [DW-1:0]  rdata
);
  localparam logic [AW-1:0] A_SEL = AW'(0);
  localparam logic [AW-1:0] A_PSC = AW'(1);
  localparam logic [AW-1:0] A_FLG = AW'(2);
  localparam logic [AW-1:0] A_CLR = AW'(3);
  localparam logic [AW-1:0] A_FRC = AW'(4);
  localparam logic [DW-1:0] SEL_MASK = DW'(16'hFF0F);
  localparam logic [DW-1:0] PSC_MASK = DW'((1 << (NCH * PSC_W)) - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q <= '0;
      psc_q <= '0;
    end else if (wr) begin
      if (addr == A_SEL) sel_q <= wdata & SEL_MASK;
      if (addr == A_PSC) psc_q <= wdata & PSC_MASK;
    end
  end

  always_comb begin
    clr_vec = (wr && addr == A_CLR) ? wdata[NCH-1:0] : '0;
    frc_vec = (wr && addr == A_FRC) ? wdata[NCH-1:0] : '0;
    case (addr)
      A_SEL:   rdata = sel_q;
      A_PSC:   rdata = psc_q;
      A_FLG:   rdata = {{(DW-NCH){1'b0}}, flags};
      default: rdata = '0;
    endcase
  end
endmodule

// File: rtl/pwm_evt_trigger.sv
module pwm_evt_trigger #(
  parameter int CW    = 16,
  parameter int DW    = 16,
  parameter int AW    = 3,
  parameter int PSC_W = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tb_tick,
  input  logic [CW-1:0] tb_count,
  input  logic          tb_dir_up,
  input  logic [CW-1:0] tb_period,
  input  logic [CW-1:0] cmp_a,
  input  logic [CW-1:0] cmp_b,
  input  logic          dc_evt_a,
  input  logic          dc_evt_b,
  input  logic          reg_wr,
  input  logic [AW-1:0] reg_addr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  output logic          irq_pulse,
  output logic          soca_pulse,
  output logic          socb_pulse
);
  import pwm_et_pkg::*;

  tb_evt_t                     tb_ev;
  logic [DW-1:0]               sel_q, psc_q;
  logic [NCH-1:0]              clr_vec, frc_vec, qual_vec, fire_vec, pulse_vec, flag_vec, dc_vec;
  logic [NCH-1:0][PSC_W-1:0]   cnt_vec, per_vec;
  logic [2:0]                  irq_code;

  assign dc_vec   = {dc_evt_b, dc_evt_a, 1'b0};
  assign irq_code = sel_q[2:0];

  et_tb_decode #(.CW(CW)) u_dec (
    .count(tb_count), .dir_up(tb_dir_up), .period(tb_period),
    .cmpa(cmp_a), .cmpb(cmp_b), .ev(tb_ev)
  );

  et_regs #(.DW(DW), .AW(AW), .NCH(NCH), .PSC_W(PSC_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
    .flags(flag_vec), .sel_q(sel_q), .psc_q(psc_q),
    .clr_vec(clr_vec), .frc_vec(frc_vec), .rdata(reg_rdata)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    localparam int SB = (c == CH_IRQ) ? 0 : (4 * c + 4);
    assign per_vec[c] = psc_q[c*PSC_W +: PSC_W];

    et_src_mux #(.DC_ALLOWED(c != CH_IRQ)) u_mux (
      .tick(tb_tick), .en(sel_q[SB+3]), .code(sel_q[SB +: 3]), .ev(tb_ev),
      .dc(dc_vec[c]), .force_ev(frc_vec[c]), .qual(qual_vec[c])
    );

    et_prescaler #(.PSC_W(PSC_W), .HOLD_ON_FL(c == CH_IRQ)) u_psc (
      .clk(clk), .rst_n(rst_n), .qual(qual_vec[c]), .per(per_vec[c]),
      .clr(clr_vec[c]), .fire(fire_vec[c]), .pulse(pulse_vec[c]),
      .flag(flag_vec[c]), .cnt(cnt_vec[c])
    );
  end

  assign irq_pulse  = pulse_vec[CH_IRQ];
  assign soca_pulse = pulse_vec[CH_SOCA];
  assign socb_pulse = pulse_vec[CH_SOCB];
endmodule

// File: rtl/pwm_et_checker.sv
module pwm_et_checker #(
  parameter int NCH   = 3,
  parameter int PSC_W = 4
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic [NCH-1:0]            pulse_vec,
  input logic [NCH-1:0]            flag_vec,
  input logic [NCH-1:0]            fire_vec,
  input logic [NCH-1:0]            clr_vec,
  input logic [NCH-1:0]            frc_vec,
  input logic [NCH-1:0][PSC_W-1:0] cnt_vec,
  input logic [NCH-1:0][PSC_W-1:0] per_vec,
  input logic [2:0]                irq_code
);
  assert_irq_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    flag_vec[0] |=> !pulse_vec[0]);

  assert_reserved_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_code == 3'd0 && !frc_vec[0]) |=> $stable(cnt_vec[0]));

  for (genvar c = 0; c < NCH; c++) begin : g_chk
    assert_pulse_sets_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
      pulse_vec[c] |-> flag_vec[c]);
    assert_pulse_restarts_R7: assert property (@(posedge clk) disable iff (!rst_n)
      pulse_vec[c] |-> (cnt_vec[c] == '0));
    assert_zero_period_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (per_vec[c] == '0) |=> !pulse_vec[c]);
    assert_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_vec[c] && !fire_vec[c]) |=> !flag_vec[c]);
    assert_set_wins_R13: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_vec[c] && fire_vec[c]) |=> flag_vec[c]);
  end
endmodule

bind pwm_evt_trigger pwm_et_checker #(.NCH(pwm_et_pkg::NCH), .PSC_W(PSC_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .pulse_vec(pulse_vec), .flag_vec(flag_vec),
  .fire_vec(fire_vec), .clr_vec(clr_vec), .frc_vec(frc_vec),
  .cnt_vec(cnt_vec), .per_vec(per_vec), .irq_code(irq_code)
);

// File: tb/pwm_evt_trigger_tb_top.sv
module pwm_evt_trigger_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tb_tick = 1'b0;
  logic [15:0] tb_count = '0;
  logic        tb_dir_up = 1'b1;
  logic [15:0] tb_period = 16'd100;
  logic [15:0] cmp_a = 16'd40;
  logic [15:0] cmp_b = 16'd70;
  logic        dc_evt_a = 1'b0, dc_evt_b = 1'b0;
  logic        reg_wr = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic        irq_pulse, soca_pulse, socb_pulse;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  pwm_evt_trigger dut_i (
    .clk(clk), .rst_n(rst_n), .tb_tick(tb_tick), .tb_count(tb_count),
    .tb_dir_up(tb_dir_up), .tb_period(tb_period), .cmp_a(cmp_a), .cmp_b(cmp_b),
    .dc_evt_a(dc_evt_a), .dc_evt_b(dc_evt_b), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_pulse(irq_pulse),
    .soca_pulse(soca_pulse), .socb_pulse(socb_pulse)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0; tb_tick = 1'b0; reg_wr = 1'b0;
    dc_evt_a = 1'b0; dc_evt_b = 1'b0; tb_period = 16'd100;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic wreg(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rreg(input logic [2:0] a, output logic [15:0] d);
    reg_addr = a; #1; d = reg_rdata;
  endtask

  // pulses {socb, soca, irq} one clock after the tick
  task automatic tick(input logic [15:0] c, input logic up, output logic [2:0] p);
    @(negedge clk); tb_count = c; tb_dir_up = up; tb_tick = 1'b1;
    @(negedge clk); tb_tick = 1'b0; p = {socb_pulse, soca_pulse, irq_pulse};
  endtask

  task automatic t_reset();
    logic [15:0] d;
    do_reset();
    rreg(3'd0, d); check("R1 sel", d, 0);
    rreg(3'd1, d); check("R1 psc", d, 0);
    rreg(3'd2, d); check("R1 flags", d, 0);
    check("R1 pulses", {socb_pulse, soca_pulse, irq_pulse}, 0);
  endtask

  task automatic t_map();
    logic [15:0] d;
    do_reset();
    wreg(3'd0, 16'hFFFF); rreg(3'd0, d); check("R2 sel reserved", d, 16'hFF0F);
    wreg(3'd1, 16'hFFFF); rreg(3'd1, d); check("R2 psc reserved", d, 16'h0FFF);
  endtask

  task automatic t_zero_prd();
    logic [2:0] p;
    do_reset();
    wreg(3'd1, 16'h0010);
    wreg(3'd0, 16'h0900);
    tick(16'd0, 1'b1, p);   check("R3 zero", p, 3'b010);
    tick(16'd5, 1'b1, p);   check("R3 no zero", p, 3'b000);
    wreg(3'd0, 16'h0A00);
    tick(16'd100, 1'b1, p); check("R3 period", p, 3'b010);
    tick(16'd0, 1'b1, p);   check("R3 period not zero", p, 3'b000);
    wreg(3'd0, 16'h0B00);
    tick(16'd0, 1'b1, p);   check("R3 either zero", p, 3'b010);
    tick(16'd100, 1'b1, p); check("R3 either prd", p, 3'b010);
    tb_period = 16'd0; wreg(3'd1, 16'h0020);
    tick(16'd0, 1'b1, p);   check("R3 single event 1st", p, 3'b000);
    tick(16'd0, 1'b1, p);   check("R3 single event 2nd", p, 3'b010);
  endtask

  task automatic t_dir();
    logic [2:0] p;
    do_reset();
    wreg(3'd1, 16'h0110);
    wreg(3'd0, 16'h0C00);
    tick(16'd40, 1'b0, p); check("R4 A-up vs down", p, 3'b000);
    tick(16'd40, 1'b1, p); check("R4 A-up", p, 3'b010);
    wreg(3'd0, 16'h0D00);
    tick(16'd40, 1'b1, p); check("R4 A-dn vs up", p, 3'b000);
    tick(16'd40, 1'b0, p); check("R4 A-dn", p, 3'b010);
    wreg(3'd0, 16'hE000);
    tick(16'd70, 1'b0, p); check("R4 B-up vs down", p, 3'b000);
    tick(16'd40, 1'b1, p); check("R4 B-up wrong value", p, 3'b000);
    tick(16'd70, 1'b1, p); check("R4 B-up", p, 3'b100);
    wreg(3'd0, 16'hF000);
    tick(16'd70, 1'b1, p); check("R4 B-dn vs up", p, 3'b000);
    tick(16'd70, 1'b0, p); check("R4 B-dn", p, 3'b100);
  endtask

  task automatic t_dc();
    logic [2:0] p; logic [15:0] d;
    do_reset();
    wreg(3'd1, 16'h0111);
    wreg(3'd0, 16'h8808);
    dc_evt_a = 1'b1; dc_evt_b = 1'b1;
    tick(16'd5, 1'b1, p); check("R5 dc events, irq silent", p, 3'b110);
    rreg(3'd2, d);        check("R5 flags", d, 16'h0006);
    dc_evt_a = 1'b0; dc_evt_b = 1'b0;
    tick(16'd5, 1'b1, p); check("R5 dc low", p, 3'b000);
  endtask

  task automatic t_enable();
    logic [2:0] p;
    do_reset();
    wreg(3'd1, 16'h0010);
    wreg(3'd0, 16'h0100);
    tick(16'd0, 1'b1, p); check("R6 disabled", p, 3'b000);
    wreg(3'd0, 16'h0900);
    tick(16'd0, 1'b1, p); check("R6 enabled", p, 3'b010);
  endtask

  task automatic t_prescale();
    logic [2:0] p;
    do_reset();
    wreg(3'd0, 16'h0900);
    wreg(3'd1, 16'h0020);
    tick(16'd0, 1'b1, p); check("R7 idle 1st", p, 3'b000);
    tb_count = 16'd0;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk); check("R7 no tick no count", soca_pulse, 1'b0);
    end
    tick(16'd0, 1'b1, p); check("R7 2nd of 2", p, 3'b010);
    @(negedge clk);       check("R7 one-clock pulse", soca_pulse, 1'b0);
    wreg(3'd1, 16'h0030);
    for (int i = 1; i <= 6; i++) begin
      tick(16'd0, 1'b1, p); check("R7 every 3rd", p[1], (i % 3) == 0);
    end
    wreg(3'd1, 16'h00F0);
    for (int i = 1; i <= 15; i++) begin
      tick(16'd0, 1'b1, p); check("R7 every 15th", p[1], i == 15);
    end
  endtask

  task automatic t_per0();
    logic [2:0] p; logic [15:0] d;
    do_reset();
    wreg(3'd0, 16'h0900);
    for (int i = 0; i < 3; i++) begin
      tick(16'd0, 1'b1, p); check("R8 period 0", p, 3'b000);
    end
    rreg(3'd2, d); check("R8 no flag", d, 0);
  endtask

  task automatic t_irq_block();
    logic [2:0] p; logic [15:0] d;
    do_reset();
    wreg(3'd1, 16'h0001);
    wreg(3'd0, 16'h0009);
    tick(16'd0, 1'b1, p); check("R9 first irq", p, 3'b001);
    rreg(3'd2, d);        check("R9 flag set", d, 16'h0001);
    tick(16'd0, 1'b1, p); check("R9 held", p, 3'b000);
    tick(16'd0, 1'b1, p); check("R9 still held", p, 3'b000);
    wreg(3'd3, 16'h0000); rreg(3'd2, d); check("R11 zero write keeps flag", d, 16'h0001);
    wreg(3'd3, 16'h0001); rreg(3'd2, d); check("R11 cleared", d, 0);
    tick(16'd0, 1'b1, p); check("R9 resumes", p, 3'b001);
  endtask

  task automatic t_soc_free();
    logic [2:0] p; logic [15:0] d;
    do_reset();
    wreg(3'd1, 16'h0010);
    wreg(3'd0, 16'h0900);
    tick(16'd0, 1'b1, p); check("R10 first", p, 3'b010);
    tick(16'd0, 1'b1, p); check("R10 flag does not block", p, 3'b010);
    rreg(3'd2, d);        check("R10 flag", d, 16'h0002);
    wreg(3'd3, 16'h0002); rreg(3'd2, d); check("R11 soc clear", d, 0);
  endtask

  task automatic t_force();
    logic [15:0] d;
    do_reset();
    wreg(3'd1, 16'h0011);
    wreg(3'd0, 16'h0100);
    wreg(3'd4, 16'h0002); check("R12 force soca", soca_pulse, 1'b1);
    rreg(3'd2, d);        check("R12 soca flag", d, 16'h0002);
    wreg(3'd4, 16'h0001); check("R12 force irq reserved code", irq_pulse, 1'b1);
    wreg(3'd4, 16'h0001); check("R12 force irq held by flag", irq_pulse, 1'b0);
    wreg(3'd4, 16'h0004); check("R12 force socb period 0", socb_pulse, 1'b0);
  endtask

  task automatic t_clr_set();
    logic [15:0] d;
    do_reset();
    wreg(3'd1, 16'h0010);
    wreg(3'd0, 16'h0900);
    @(negedge clk); tb_count = 16'd0; tb_tick = 1'b1;
    reg_wr = 1'b1; reg_addr = 3'd3; reg_wdata = 16'h0002;
    @(negedge clk); tb_tick = 1'b0; reg_wr = 1'b0;
    check("R13 pulse", soca_pulse, 1'b1);
    rreg(3'd2, d); check("R13 set wins", d, 16'h0002);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_map();
    t_zero_prd();
    t_dir();
    t_dc();
    t_enable();
    t_prescale();
    t_per0();
    t_irq_block();
    t_soc_free();
    t_force();
    t_clr_set();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule